// File: doc/BRIEF.md
# Disk Head Positioning and Index Unit

This block keeps track of head position for a hard disk interface with two drives. The host reaches it through a small register port. One write sets the step direction. Another write latches the step bit and the drive selection. A third write selects the head. A fourth write restarts an index countdown. Each drive has its own cylinder counter. A counter moves by one only when the step bit goes from 0 to 1, and it never moves below zero or above that drive's configured cylinder limit. A drive built as absent never moves.

No rotating medium is modelled, so the index indication is synthesised. A countdown is loaded by the restart command and decremented by each read of the first status register. The index bit reads as set once the count has reached zero. The cylinder counters, the head and the drive selection are brought out as ports, so the positioning logic around the block can use them directly.

Top module: `head_pos_ctrl`

## Requirements
- R1: After reset, both cylinder counters are 0, the head is 0, drive 0 is selected, the step and direction state are 0, and the index countdown holds IDX_RELOAD (10).
- R2: A write to offset 0 sets the direction from data bit 7. A value of 1 makes the next step increment the cylinder, and 0 makes it decrement.
- R3: A write to offset 3 steps the selected drive only when data bit 0 is 1 and the latched step bit is 0. Every offset-3 write then latches bit 0 as the new step bit. Writing 1 while the latch already holds 1 leaves the cylinder unchanged.
- R4: A decrement step at cylinder 0 is ignored. An increment step is ignored when the cylinder is not below the drive's limit (CYL_MAX0 = 12, CYL_MAX1 = 5).
- R5: A drive whose presence parameter is 0 never steps, and its cylinder stays at 0.
- R6: Data bit 3 of an offset-3 write selects the drive. The step caused by that same write applies to the drive selected before the write.
- R7: A write to offset 2 sets the head to data bits 2:0. No other write changes the head.
- R8: A write to offset 1 loads the index countdown with IDX_RELOAD. Each read of offset 0 decrements a nonzero count. Read bit 15 is 1 when the count before that read was zero. After a restart, reads 1 to 10 show 0 and every later read shows 1.
- R9: Read offset 0 returns the index flag in bit 15, the drive in bit 3 and the head in bits 2:0, with all other bits 0. Read offset 1 returns the cylinder of the selected drive. Offsets 2 and 3 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register offset |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data (combinational) |
| cyl0 | output | CYL_W | Cylinder of drive 0 |
| cyl1 | output | CYL_W | Cylinder of drive 1 |
| head_sel | output | 3 | Selected head |
| drive_sel | output | 1 | Selected drive |

## Verification
On every cycle, the assertions check several properties. Each cylinder stays within its limit. A cylinder changes only on a rising step write to its drive, and then by exactly one in the latched direction. An absent drive stays at zero. The head changes only on a head write. The index restart reloads the countdown. The bench scenarios show the parts that no single-cycle property captures. These are the clamping at both ends during long step runs, and the step landing on the previously selected drive when one write changes the drive. They also cover the exact read on which the index flag first appears, and the combined effect of long random mixes of writes and reads on the status words.

// File: rtl/head_pos_ctrl.sv
module head_pos_ctrl #(
  parameter int CYL_W        = 16,
  parameter int CYL_MAX0     = 12,
  parameter int CYL_MAX1     = 5,
  parameter bit DRV0_PRESENT = 1'b1,
  parameter bit DRV1_PRESENT = 1'b1,
  parameter int IDX_RELOAD   = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [1:0]       addr,
  input  logic [15:0]      wdata,
  output logic [15:0]      rdata,
  output logic [CYL_W-1:0] cyl0,
  output logic [CYL_W-1:0] cyl1,
  output logic [2:0]       head_sel,
  output logic             drive_sel
);
  localparam int IDX_W = $clog2(IDX_RELOAD + 1);
  localparam logic [1:0] W_DIR = 2'd0, W_IDX = 2'd1, W_HEAD = 2'd2, W_CTRL = 2'd3;
  localparam logic [1:0] R_STAT1 = 2'd0, R_STAT2 = 2'd1;

  logic             step_q, dir_q, drive_q;
  logic [2:0]       head_q;
  logic [IDX_W-1:0] idx_cnt;
  logic [CYL_W-1:0] cyl_q [2];

  wire step_fire = wr_en && addr == W_CTRL && wdata[0] && !step_q;
  wire stat1_rd  = rd_en && addr == R_STAT1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step_q  <= 1'b0;
      dir_q   <= 1'b0;
      drive_q <= 1'b0;
      head_q  <= '0;
      idx_cnt <= IDX_W'(IDX_RELOAD);
    end else begin
      if (wr_en && addr == W_DIR) dir_q <= wdata[7];
      if (wr_en && addr == W_HEAD) head_q <= wdata[2:0];
      if (wr_en && addr == W_CTRL) begin
        step_q  <= wdata[0];
        drive_q <= wdata[3];
      end
      if (wr_en && addr == W_IDX) idx_cnt <= IDX_W'(IDX_RELOAD);
      else if (stat1_rd && idx_cnt != '0) idx_cnt <= idx_cnt - 1'b1;
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_drv
    localparam int LIM = (g == 0) ? CYL_MAX0 : CYL_MAX1;
    localparam bit PRESENT = (g == 0) ? DRV0_PRESENT : DRV1_PRESENT;
    wire hit = step_fire && drive_q == 1'(g) && PRESENT;

    always_ff @(posedge clk) begin
      if (!rst_n) cyl_q[g] <= '0;
      else if (hit) begin
        if (dir_q && cyl_q[g] < CYL_W'(LIM)) cyl_q[g] <= cyl_q[g] + 1'b1;
        else if (!dir_q && cyl_q[g] != '0) cyl_q[g] <= cyl_q[g] - 1'b1;
      end
    end

    assert_cyl_clamp_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cyl_q[g] <= CYL_W'(LIM));
    assert_step_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(step_fire && drive_q == 1'(g)) |=> $stable(cyl_q[g]));
    assert_step_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (step_fire && drive_q == 1'(g) && dir_q && PRESENT && cyl_q[g] < CYL_W'(LIM))
        |=> cyl_q[g] == $past(cyl_q[g]) + 1'b1);
    if (!PRESENT) begin : g_absent
      assert_absent_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cyl_q[g] == '0);
    end
  end

  assert_head_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == W_HEAD) |=> $stable(head_q));
  assert_idx_reload_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == W_IDX) |=> idx_cnt == IDX_W'(IDX_RELOAD));

  always_comb begin
    case (addr)
      R_STAT1: rdata = {idx_cnt == '0, 11'b0, drive_q, head_q};
      R_STAT2: rdata = 16'(cyl_q[drive_q]);
      default: rdata = '0;
    endcase
  end

  assign cyl0      = cyl_q[0];
  assign cyl1      = cyl_q[1];
  assign head_sel  = head_q;
  assign drive_sel = drive_q;
endmodule

// File: tb/test_head_pos_ctrl.sv
module test_head_pos_ctrl;
  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
  logic [1:0] addr = 0;
  logic [15:0] wdata = 0, rdata, rdata_b;
  logic [15:0] cyl0, cyl1, cyl0_b, cyl1_b;
  logic [2:0] head_sel, head_b;
  logic drive_sel, drive_b;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  head_pos_ctrl i_head_pos_ctrl (.clk, .rst_n, .wr_en, .rd_en, .addr, .wdata,
    .rdata, .cyl0, .cyl1, .head_sel, .drive_sel);
  head_pos_ctrl #(.DRV1_PRESENT(1'b0)) i_absent (.clk, .rst_n, .wr_en, .rd_en,
    .addr, .wdata, .rdata(rdata_b), .cyl0(cyl0_b), .cyl1(cyl1_b),
    .head_sel(head_b), .drive_sel(drive_b));

  int e_cyl [2];
  int lim [2] = '{12, 5};
  bit e_step, e_dir, e_drv;
  int e_head, e_cnt;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s actual=%0d expected=%0d", req, act, exp); end
  endtask

  function automatic int nxt_cyl(int c, bit dir, int l);
    if (dir) return (c < l) ? c + 1 : c;
    return (c > 0) ? c - 1 : c;
  endfunction

  task automatic wr(logic [1:0] a, logic [15:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    case (a)
      2'd0: e_dir = d[7];
      2'd1: e_cnt = 10;
      2'd2: e_head = d[2:0];
      2'd3: begin
        if (d[0] && !e_step) e_cyl[e_drv] = nxt_cyl(e_cyl[e_drv], e_dir, lim[e_drv]);
        e_step = d[0]; e_drv = d[3];
      end
    endcase
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [15:0] v);
    @(negedge clk); rd_en = 1; addr = a; #1 v = rdata;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic check_state(string req);
    chk(cyl0 == e_cyl[0], {req, " cyl0"}, cyl0, e_cyl[0]);
    chk(cyl1 == e_cyl[1], {req, " cyl1"}, cyl1, e_cyl[1]);
    chk(head_sel == e_head, {req, " head"}, head_sel, e_head);
    chk(drive_sel == e_drv, {req, " drive"}, drive_sel, e_drv);
    chk(cyl1_b == 0, "R5 absent cyl1", cyl1_b, 0);
    chk(cyl0_b == e_cyl[0], "R5 present cyl0 of second instance", cyl0_b, e_cyl[0]);
  endtask

  task automatic rd_stat1(string req);
    logic [15:0] v; int exp;
    rd(2'd0, v);
    exp = ((e_cnt <= 0) ? 32'h8000 : 0) | (int'(e_drv) << 3) | e_head;
    if (e_cnt > 0) e_cnt--;
    chk(v == exp, req, v, exp);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    void'($urandom(32'd4242));
    e_cyl = '{0, 0}; e_step = 0; e_dir = 0; e_drv = 0; e_head = 0; e_cnt = 10;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_state("R1 reset");
    rd(2'd1, v); chk(v == 0, "R1 R9 reset stat2", v, 0);
    rd(2'd2, v); chk(v == 0, "R9 unused offset", v, 0);

    // R2 R4: climb past limit on drive 0
    wr(2'd0, 16'h0080);
    for (int i = 0; i < 14; i++) begin wr(2'd3, 16'h0001); wr(2'd3, 16'h0000); end
    check_state("R4 upper clamp");
    chk(cyl0 == 12, "R4 at limit", cyl0, 12);
    // R3: repeated 1 writes do not step
    wr(2'd0, 16'h0000);
    wr(2'd3, 16'h0001); wr(2'd3, 16'h0001); wr(2'd3, 16'h0001);
    chk(cyl0 == 11, "R3 level held no extra step", cyl0, 11);
    // R2 R4: descend past zero
    for (int i = 0; i < 14; i++) begin wr(2'd3, 16'h0000); wr(2'd3, 16'h0001); end
    chk(cyl0 == 0, "R4 lower clamp", cyl0, 0);
    check_state("R2 descend");
    // R6: step uses previous drive, selection changes after
    wr(2'd3, 16'h0000); wr(2'd0, 16'h0080);
    wr(2'd3, 16'h0009);
    chk(cyl0 == 1, "R6 step on old drive", cyl0, 1);
    chk(cyl1 == 0, "R6 new drive untouched", cyl1, 0);
    chk(drive_sel == 1, "R6 drive updated", drive_sel, 1);
    wr(2'd3, 16'h0008); wr(2'd3, 16'h0009);
    chk(cyl1 == 1, "R6 drive1 step", cyl1, 1);
    chk(cyl1_b == 0, "R5 absent no step", cyl1_b, 0);
    rd(2'd1, v); chk(v == 1, "R9 stat2 selected cyl", v, 1);
    // R7 head
    wr(2'd2, 16'hFFFD);
    chk(head_sel == 5, "R7 head low bits", head_sel, 5);
    // R8 index countdown
    wr(2'd1, 16'h0000);
    for (int i = 0; i < 13; i++) rd_stat1("R8 R9 index countdown");
    wr(2'd1, 16'h0000);
    rd_stat1("R8 restart clears flag");

    // random mix
    for (int n = 0; n < 600; n++) begin
      int op = $urandom_range(0, 9);
      logic [15:0] d = 16'($urandom);
      case (op)
        0: wr(2'd0, d);
        1: if ($urandom_range(0, 3) == 0) wr(2'd1, d);
        2: wr(2'd2, d);
        3, 4, 5: wr(2'd3, d & 16'h0009);
        6, 7: rd_stat1("R8 R9 random stat1");
        8: begin rd(2'd1, v); chk(v == e_cyl[e_drv], "R9 random stat2", v, e_cyl[e_drv]); end
        default: wr(2'd3, {12'b0, e_drv, 3'b0} ^ 16'h0001);
      endcase
      check_state("R2 R3 R4 R6 R7 random");
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule